// File: doc/BRIEF.md
# Video Input Sample Window

This block decides which incoming video pixels lie inside a programmable rectangular capture region. It watches a pixel-valid strobe together with a horizontal line reference and a vertical frame reference. It asserts a sample-enable for every pixel that falls inside the rectangle. Four programmed values place the rectangle: a horizontal and a vertical offset, and a horizontal and a vertical size. The block also marks the first sampled pixel of each frame and every sampled pixel on the last line of the window.

Two events drive all counting. A frame starts when the vertical reference goes from its active level back to inactive. A line starts when the line reference goes from inactive to active. After a line start, each valid pixel seen while the line reference is active advances the pixel position by one. After a frame start, each line start advances the line position by one. A polarity input for each reference selects which level counts as active. Offset and size values are copied into working registers only at a frame start, so a change made mid-frame cannot tear the window.

Top module: `video_sample_window`

## Requirements
- R1: `sampleEn` is high only in a cycle where `pixValid` is high, the line reference is at its active level, and that cycle is not the line-start cycle itself. A valid strobe during line blanking or on the line-start cycle is never sampled.
- R2: Within a line, let k be the number of counted pixels before the current one since the line start, with the first counted pixel at k = 0. A pixel in a window line is sampled exactly when hOffset <= k < hOffset + hSize. Cycles with `pixValid` low do not advance k.
- R3: Let n be the zero-based index of a line since the frame start, where the first line start after the frame start gives n = 0. The pixels of a line can be sampled exactly when vOffset <= n < vOffset + vSize.
- R4: A frame start happens only on the active-to-inactive transition of the vertical reference. The inactive-to-active transition has no effect on counting or sampling.
- R5: A line start happens on the inactive-to-active transition of the line reference. It restarts k at 0 and advances n.
- R6: `hRefActHigh`/`vRefActHigh` = 1 makes the high level active, and 0 makes the low level active. Each reference has its own setting.
- R7: With both offsets at 0, the first counted pixel of the first line after a frame start is sampled.
- R8: `firstPix` is high together with `sampleEn` exactly for the pixel at n = vOffset, k = hOffset.
- R9: `lastLine` is high together with `sampleEn` for every sampled pixel of line n = vOffset + vSize - 1, and is low otherwise.
- R10: Offset and size inputs are captured only in the frame-start cycle. A change applied mid-frame has no effect until the next frame start.
- R11: A captured hSize or vSize of 0 yields no samples. After reset, nothing is sampled until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Pixel present on this cycle |
| hRef | input | 1 | Horizontal line reference |
| vRef | input | 1 | Vertical frame reference |
| hRefActHigh | input | 1 | 1: hRef active high; 0: active low |
| vRefActHigh | input | 1 | 1: vRef active high; 0: active low |
| hOffset | input | HW | Counted pixels skipped before the window |
| vOffset | input | VW | Lines skipped before the window |
| hSize | input | HW | Window width in pixels |
| vSize | input | VW | Window height in lines |
| sampleEn | output | 1 | Current pixel lies inside the window |
| firstPix | output | 1 | Current sampled pixel is the first of the frame |
| lastLine | output | 1 | Current sampled pixel is on the last window line |

## Verification
Several properties are checked on every cycle by the assertions. An enable never appears without an eligible pixel. Neither marker appears without an enable. Each edge strobe lasts a single cycle. The working configuration holds steady between frame starts. The line count clears after a frame start. Only the directed scenarios can show that the window lands on the right pixels and lines. Those scenarios cover the offset and size arithmetic, polarity inversion, pixel gaps, the ignored leading vertical edge, deferred configuration changes and empty windows, and each one compares every pixel against a position model kept in the bench.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

  // Strobes passed from the edge-detect control to the counting datapath.
  typedef struct packed {
    logic frameStart;  // vertical reference left its active level
    logic lineStart;   // horizontal reference entered its active level
    logic pixLive;     // valid pixel inside an active line, not the edge cycle
  } winStrobe_t;

endpackage

// File: rtl/vwin_control.sv
module vwin_control
  import vwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       hRef,
  input  logic       vRef,
  input  logic       hRefActHigh,
  input  logic       vRefActHigh,
  output winStrobe_t stb
);

  logic hLvl, vLvl;
  logic hPrev, vPrev;

  // Normalise both references so that 1 always means "active".
  assign hLvl = hRefActHigh ? hRef : ~hRef;
  assign vLvl = vRefActHigh ? vRef : ~vRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= hLvl;
      vPrev <= vLvl;
    end
  end

  always_comb begin
    stb.lineStart  = hLvl & ~hPrev;
    stb.frameStart = ~vLvl & vPrev;
    stb.pixLive    = pixValid & hLvl & hPrev;
  end

  // R5: a line start can never persist into the following cycle
  p_line_edge_single_r5 : assert property (@(posedge clk) disable iff (!rstN)
    stb.lineStart |=> !stb.lineStart);

  // R4: a frame start is a one-cycle event
  p_frame_edge_single_r4 : assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStart |=> !stb.frameStart);

  // R1: the edge cycle is never an eligible pixel
  p_no_pix_on_edge_r1 : assert property (@(posedge clk) disable iff (!rstN)
    stb.pixLive |-> !stb.lineStart);

endmodule

// File: rtl/vwin_datapath.sv
module vwin_datapath
  import vwin_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  winStrobe_t    stb,
  input  logic [HW-1:0] hOffset,
  input  logic [VW-1:0] vOffset,
  input  logic [HW-1:0] hSize,
  input  logic [VW-1:0] vSize,
  output logic          sampleEn,
  output logic          firstPix,
  output logic          lastLine
);

  localparam logic [HW-1:0] PIX_MAX  = {HW{1'b1}};
  localparam logic [VW-1:0] LINE_MAX = {VW{1'b1}};
  localparam logic [VW:0]   ONE_V    = {{VW{1'b0}}, 1'b1};

  // Working copies, refreshed only at frame start
  logic [HW-1:0] hOffA, hSizeA;
  logic [VW-1:0] vOffA, vSizeA;

  logic [HW-1:0] pixCnt;   // counted pixels in this line
  logic [VW-1:0] lineCnt;  // line starts since frame start

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hOffA   <= '0;
      hSizeA  <= '0;
      vOffA   <= '0;
      vSizeA  <= '0;
      lineCnt <= '0;
    end else if (stb.frameStart) begin
      hOffA   <= hOffset;
      hSizeA  <= hSize;
      vOffA   <= vOffset;
      vSizeA  <= vSize;
      lineCnt <= '0;
    end else if (stb.lineStart && lineCnt != LINE_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (stb.lineStart) begin
      pixCnt <= '0;
    end else if (stb.pixLive && pixCnt != PIX_MAX) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  logic [HW:0] hEnd;
  logic [VW:0] vEnd, lineNum;
  logic        inH, inV;

  always_comb begin
    hEnd     = {1'b0, hOffA} + {1'b0, hSizeA};
    vEnd     = {1'b0, vOffA} + {1'b0, vSizeA};
    lineNum  = {1'b0, lineCnt};
    inH      = (pixCnt >= hOffA) && ({1'b0, pixCnt} < hEnd);
    inV      = (lineNum > {1'b0, vOffA}) && (lineNum <= vEnd);
    sampleEn = stb.pixLive && inH && inV;
    firstPix = sampleEn && (pixCnt == hOffA) && (lineNum == {1'b0, vOffA} + ONE_V);
    lastLine = sampleEn && (lineNum == vEnd);
  end

  // R1: an enable needs an eligible pixel from the control side
  p_en_has_pixel_r1 : assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> stb.pixLive);

  // R8: the first-pixel marker sits on a sampled pixel
  p_first_is_sampled_r8 : assert property (@(posedge clk) disable iff (!rstN)
    firstPix |-> sampleEn);

  // R9: the last-line marker sits on a sampled pixel
  p_last_is_sampled_r9 : assert property (@(posedge clk) disable iff (!rstN)
    lastLine |-> sampleEn);

  // R10: working configuration moves only on a frame start
  p_cfg_hold_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameStart |=> ($stable(hOffA) && $stable(hSizeA) &&
                         $stable(vOffA) && $stable(vSizeA)));

  // R4: line numbering restarts after a frame start
  p_line_clear_r4 : assert property (@(posedge clk) disable iff (!rstN)
    stb.frameStart |=> (lineCnt == '0));

endmodule

// File: rtl/video_sample_window.sv
module video_sample_window
  import vwin_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          hRef,
  input  logic          vRef,
  input  logic          hRefActHigh,
  input  logic          vRefActHigh,
  input  logic [HW-1:0] hOffset,
  input  logic [VW-1:0] vOffset,
  input  logic [HW-1:0] hSize,
  input  logic [VW-1:0] vSize,
  output logic          sampleEn,
  output logic          firstPix,
  output logic          lastLine
);

  winStrobe_t stb;

  vwin_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .pixValid    (pixValid),
    .hRef        (hRef),
    .vRef        (vRef),
    .hRefActHigh (hRefActHigh),
    .vRefActHigh (vRefActHigh),
    .stb         (stb)
  );

  vwin_datapath #(.HW(HW), .VW(VW)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hOffset  (hOffset),
    .vOffset  (vOffset),
    .hSize    (hSize),
    .vSize    (vSize),
    .sampleEn (sampleEn),
    .firstPix (firstPix),
    .lastLine (lastLine)
  );

endmodule

// File: tb/test_video_sample_window.sv
module test_video_sample_window;

  localparam int HW = 12;
  localparam int VW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pixValid = 1'b0;
  logic          hLvl = 1'b0, vLvl = 1'b0;
  logic          hPol = 1'b1, vPol = 1'b1;
  logic          hRef, vRef;
  logic [HW-1:0] hOffset = '0, hSize = '0;
  logic [VW-1:0] vOffset = '0, vSize = '0;
  logic          sampleEn, firstPix, lastLine;

  int compared = 0;
  int mismatched = 0;

  assign hRef = hPol ? hLvl : ~hLvl;
  assign vRef = vPol ? vLvl : ~vLvl;

  always #10 clk = ~clk;  // 50 MHz

  video_sample_window #(.HW(HW), .VW(VW)) i_video_sample_window (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .hRef(hRef), .vRef(vRef),
    .hRefActHigh(hPol), .vRefActHigh(vPol),
    .hOffset(hOffset), .vOffset(vOffset), .hSize(hSize), .vSize(vSize),
    .sampleEn(sampleEn), .firstPix(firstPix), .lastLine(lastLine)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, then check away from the rising edge.
  task automatic drive(input logic hl, input logic vl, input logic pv);
    @(negedge clk);
    hLvl = hl; vLvl = vl; pixValid = pv;
    #2;
  endtask

  task automatic setCfg(input int ho, input int vo, input int hs, input int vs);
    hOffset = HW'(ho); vOffset = VW'(vo); hSize = HW'(hs); vSize = VW'(vs);
  endtask

  // One frame: optional frame start, then nLines lines of nPix pixel cycles.
  task automatic runFrame(input string req, input bit doStart, input int nLines,
                          input int nPix, input bit gaps, input int leadAt,
                          input int chgAt, input int cho, input int cvo,
                          input int chs, input int cvs);
    int eHO = 0, eVO = 0, eHS = 0, eVS = 0;
    if (doStart) begin
      drive(0, 1, 0);
      drive(0, 1, 0);
      drive(0, 0, 0);  // trailing vertical edge: configuration captured here
      eHO = hOffset; eVO = vOffset; eHS = hSize; eVS = vSize;
    end
    for (int n = 0; n < nLines; n++) begin
      logic vl = (leadAt >= 0 && n >= leadAt);
      int k = 0;
      if (n == chgAt) setCfg(cho, cvo, chs, cvs);
      drive(0, vl, 1);
      chk("R1", "blank sampleEn", sampleEn, 1'b0);
      drive(0, vl, 0);
      drive(1, vl, 1);
      chk("R5", "edge sampleEn", sampleEn, 1'b0);
      for (int p = 0; p < nPix; p++) begin
        logic pv = gaps ? logic'((p % 3) != 2) : 1'b1;
        logic inV = doStart && (n >= eVO) && (n < eVO + eVS);
        logic inH = (k >= eHO) && (k < eHO + eHS);
        logic eEn = pv && inV && inH;
        drive(1, vl, pv);
        chk(req, "sampleEn", sampleEn, eEn);
        chk("R8", "firstPix", firstPix, eEn && n == eVO && k == eHO);
        chk("R9", "lastLine", lastLine, eEn && n == eVO + eVS - 1);
        if (pv) k++;
      end
      drive(0, vl, 0);
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    setCfg(1, 0, 3, 2);
    drive(0, 0, 1);
    chk("R11", "reset sampleEn", sampleEn, 1'b0);
    chk("R11", "reset firstPix", firstPix, 1'b0);
    chk("R11", "reset lastLine", lastLine, 1'b0);
    @(negedge clk); rstN = 1'b1;
    // no frame start yet: nothing may be sampled
    runFrame("R11", 0, 3, 6, 0, -1, -1, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    setCfg(2, 1, 4, 2);
    runFrame("R2 R3", 1, 5, 10, 0, -1, -1, 0, 0, 0, 0);
  endtask

  task automatic t_zero_off;
    setCfg(0, 0, 3, 2);
    runFrame("R7", 1, 4, 6, 0, -1, -1, 0, 0, 0, 0);
  endtask

  task automatic t_polarity;
    hPol = 1'b0; vPol = 1'b0;
    setCfg(1, 2, 5, 1);
    runFrame("R6", 1, 4, 8, 0, -1, -1, 0, 0, 0, 0);
    hPol = 1'b1; vPol = 1'b0;
    setCfg(0, 1, 2, 2);
    runFrame("R6", 1, 4, 5, 0, -1, -1, 0, 0, 0, 0);
    hPol = 1'b1; vPol = 1'b1;
  endtask

  task automatic t_gaps;
    setCfg(1, 1, 4, 2);
    runFrame("R1 R2", 1, 4, 12, 1, -1, -1, 0, 0, 0, 0);
  endtask

  task automatic t_config;
    setCfg(1, 1, 3, 2);
    runFrame("R10", 1, 4, 7, 0, -1, 1, 0, 0, 2, 1);
    runFrame("R10", 1, 3, 5, 0, -1, -1, 0, 0, 0, 0);
  endtask

  task automatic t_lead;
    setCfg(1, 1, 3, 4);
    runFrame("R4", 1, 6, 6, 0, 2, -1, 0, 0, 0, 0);
  endtask

  task automatic t_size0;
    setCfg(0, 0, 0, 3);
    runFrame("R11", 1, 3, 5, 0, -1, -1, 0, 0, 0, 0);
    setCfg(0, 0, 3, 0);
    runFrame("R11", 1, 3, 5, 0, -1, -1, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_zero_off();
    t_polarity();
    t_gaps();
    t_config();
    t_lead();
    t_size0();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule